// File: doc/BRIEF.md
# Runahead Mode Controller

This controller decides whether a simple in-order core is executing normally or speculating past a level-one cache miss. When the core reports an instruction or data miss, the controller does not stall the core. It saves the program counter of the faulting instruction and asks the register file to take a checkpoint. If no fill for the missing line is already in flight, it also issues a demand fill. The core then keeps executing speculatively, and the controller stops any store from writing memory.

While the episode lasts, any further miss is turned into a prefetch request and the saved state is left untouched. When the fill for the original line comes back, the controller spends one cycle asking for a register restore and redirecting fetch to the saved address. Normal execution resumes on the cycle after that.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the unit is in normal mode. All request pulses are low, and `storeCommit` follows `storeValid`.
- R2: A miss (`missValid` high) sampled in normal mode makes `runahead` go high at the next clock edge. `ckptReq` is high for exactly that one cycle.
- R3: On entry, `missPc` is captured and shown on `redirectPc`. It stays unchanged until the episode ends.
- R4: On entry, `demandReq` pulses for one cycle with `demandLineAddr` equal to the missing line, but only if `fillBusy` was low when the miss was sampled.
- R5: On entry caused by a load (`missIsLoad` high), `invalidateReq` pulses for one cycle with `invalidateReg` equal to `missDestReg`. For any other trigger it stays low.
- R6: `storeCommit` is low whenever `runahead` is high, including the restore cycle. In normal mode it equals `storeValid`.
- R7: A miss sampled during runahead produces a one-cycle `prefetchReq` with `prefetchLineAddr` set to that miss's line. It raises no `ckptReq` or `demandReq` and does not change `redirectPc`.
- R8: A `fillDone` whose `fillLineAddr` equals the saved line, sampled during runahead, is followed in the next cycle by `restoreReq` and `redirectValid`. Both are high for that single cycle, together, while `runahead` is still high. In the cycle after that the unit is in normal mode.
- R9: A `fillDone` for any other line, or any `fillDone` in normal mode, has no effect on mode or outputs.
- R10: A miss sampled during the restore cycle is dropped. It starts no episode and causes no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A level-one instruction or data miss is reported this cycle |
| missIsLoad | input | 1 | The missing access is a load with a destination register |
| missPc | input | PC_W | Address of the faulting instruction |
| missLineAddr | input | LINE_W | Line address that missed |
| missDestReg | input | REG_W | Destination register of the faulting load |
| fillBusy | input | 1 | A fill for the missing line is already outstanding |
| fillDone | input | 1 | A line fill completes this cycle |
| fillLineAddr | input | LINE_W | Line address of the completed fill |
| storeValid | input | 1 | A store wants to write memory this cycle |
| runahead | output | 1 | High while in runahead, including the restore cycle |
| ckptReq | output | 1 | One-cycle register checkpoint request |
| demandReq | output | 1 | One-cycle demand fill request |
| demandLineAddr | output | LINE_W | Line for the demand fill |
| invalidateReq | output | 1 | One-cycle request to flag a register invalid |
| invalidateReg | output | REG_W | Register to flag invalid |
| prefetchReq | output | 1 | One-cycle prefetch request |
| prefetchLineAddr | output | LINE_W | Line for the prefetch |
| storeCommit | output | 1 | Store may write memory |
| restoreReq | output | 1 | One-cycle register restore request |
| redirectValid | output | 1 | One-cycle fetch redirect |
| redirectPc | output | PC_W | Saved faulting PC, the redirect target |

## Verification
On every cycle, the assertions check:
- that a store never commits while `runahead` is high;
- that the checkpoint pulse appears only on the first runahead cycle;
- that the demand pulse never appears without the checkpoint pulse;
- that the saved PC holds steady across the episode;
- that restore and redirect rise together and are followed by normal mode;
- that prefetches appear only inside an episode.

Only the bench scenarios can show the rest:
- that the captured addresses and register index are the right values;
- that the demand fill is suppressed when a fill is already outstanding;
- that fills for other lines are ignored;
- that a miss arriving in the restore cycle is dropped.

// File: rtl/runahead_pkg.sv
package runahead_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_RUNAHEAD = 2'd1,
    MODE_EXIT     = 2'd2
  } mode_e;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic enter;        // capture faulting PC/line, raise checkpoint
    logic issueDemand;  // raise demand fill
    logic markInv;      // flag load destination invalid
    logic prefetch;     // convert a runahead miss into a prefetch
  } strobe_t;

endpackage

// File: rtl/runahead_fsm.sv
module runahead_fsm
  import runahead_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    missValid,
  input  logic    missIsLoad,
  input  logic    fillBusy,
  input  logic    fillMatch,
  output strobe_t strobes,
  output mode_e   mode
);

  mode_e modeNext;

  always_comb begin
    strobes  = '0;
    modeNext = mode;
    case (mode)
      MODE_NORMAL: begin
        if (missValid) begin
          strobes.enter       = 1'b1;
          strobes.issueDemand = ~fillBusy;
          strobes.markInv     = missIsLoad;
          modeNext            = MODE_RUNAHEAD;
        end
      end
      MODE_RUNAHEAD: begin
        strobes.prefetch = missValid;
        if (fillMatch) modeNext = MODE_EXIT;
      end
      MODE_EXIT: modeNext = MODE_NORMAL;
      default:   modeNext = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_NORMAL;
    else        mode <= modeNext;
  end

endmodule

// File: rtl/runahead_datapath.sv
module runahead_datapath
  import runahead_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int LINE_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [PC_W-1:0]   missPc,
  input  logic [LINE_W-1:0] missLineAddr,
  input  logic [REG_W-1:0]  missDestReg,
  input  logic              fillDone,
  input  logic [LINE_W-1:0] fillLineAddr,
  output logic              fillMatch,
  output logic              ckptReq,
  output logic              demandReq,
  output logic [LINE_W-1:0] demandLineAddr,
  output logic              invalidateReq,
  output logic [REG_W-1:0]  invalidateReg,
  output logic              prefetchReq,
  output logic [LINE_W-1:0] prefetchLineAddr,
  output logic [PC_W-1:0]   savedPc
);

  logic [LINE_W-1:0] savedLine;

  assign fillMatch      = fillDone && (fillLineAddr == savedLine);
  assign demandLineAddr = savedLine;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      savedPc          <= '0;
      savedLine        <= '0;
      invalidateReg    <= '0;
      prefetchLineAddr <= '0;
      ckptReq          <= 1'b0;
      demandReq        <= 1'b0;
      invalidateReq    <= 1'b0;
      prefetchReq      <= 1'b0;
    end else begin
      ckptReq       <= strobes.enter;
      demandReq     <= strobes.issueDemand;
      invalidateReq <= strobes.markInv;
      prefetchReq   <= strobes.prefetch;
      if (strobes.enter) begin
        savedPc   <= missPc;
        savedLine <= missLineAddr;
      end
      if (strobes.markInv)  invalidateReg    <= missDestReg;
      if (strobes.prefetch) prefetchLineAddr <= missLineAddr;
    end
  end

endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import runahead_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int LINE_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic              missIsLoad,
  input  logic [PC_W-1:0]   missPc,
  input  logic [LINE_W-1:0] missLineAddr,
  input  logic [REG_W-1:0]  missDestReg,
  input  logic              fillBusy,
  input  logic              fillDone,
  input  logic [LINE_W-1:0] fillLineAddr,
  input  logic              storeValid,
  output logic              runahead,
  output logic              ckptReq,
  output logic              demandReq,
  output logic [LINE_W-1:0] demandLineAddr,
  output logic              invalidateReq,
  output logic [REG_W-1:0]  invalidateReg,
  output logic              prefetchReq,
  output logic [LINE_W-1:0] prefetchLineAddr,
  output logic              storeCommit,
  output logic              restoreReq,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc
);

  strobe_t strobes;
  mode_e   mode;
  logic    fillMatch;

  runahead_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .missValid  (missValid),
    .missIsLoad (missIsLoad),
    .fillBusy   (fillBusy),
    .fillMatch  (fillMatch),
    .strobes    (strobes),
    .mode       (mode)
  );

  runahead_datapath #(.PC_W(PC_W), .LINE_W(LINE_W), .REG_W(REG_W)) u_dp (
    .clk              (clk),
    .rst_n            (rst_n),
    .strobes          (strobes),
    .missPc           (missPc),
    .missLineAddr     (missLineAddr),
    .missDestReg      (missDestReg),
    .fillDone         (fillDone),
    .fillLineAddr     (fillLineAddr),
    .fillMatch        (fillMatch),
    .ckptReq          (ckptReq),
    .demandReq        (demandReq),
    .demandLineAddr   (demandLineAddr),
    .invalidateReq    (invalidateReq),
    .invalidateReg    (invalidateReg),
    .prefetchReq      (prefetchReq),
    .prefetchLineAddr (prefetchLineAddr),
    .savedPc          (redirectPc)
  );

  assign runahead      = (mode != MODE_NORMAL);
  assign storeCommit   = storeValid && (mode == MODE_NORMAL);
  assign restoreReq    = (mode == MODE_EXIT);
  assign redirectValid = (mode == MODE_EXIT);

endmodule

// File: rtl/runahead_ctrl_checker.sv
module runahead_ctrl_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            runahead,
  input logic            ckptReq,
  input logic            demandReq,
  input logic            prefetchReq,
  input logic            storeCommit,
  input logic            restoreReq,
  input logic            redirectValid,
  input logic [PC_W-1:0] redirectPc
);

  // R6: no store reaches memory while speculating
  assert_no_spec_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    runahead |-> !storeCommit);

  // R2: checkpoint only on the first cycle of an episode
  assert_ckpt_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ckptReq |-> (runahead && !$past(runahead)));

  // R4: demand fill only together with entry
  assert_demand_with_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    demandReq |-> ckptReq);

  // R3: saved PC held throughout an episode
  assert_pc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead && !ckptReq) |-> $stable(redirectPc));

  // R8: restore and redirect coincide, last one cycle, then normal mode
  assert_restore_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restoreReq |-> (redirectValid && runahead));
  assert_restore_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restoreReq |=> (!runahead && !restoreReq && !redirectValid));

  // R7: prefetches only from inside an episode
  assert_prefetch_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prefetchReq |-> (runahead && $past(runahead)));

endmodule

bind runahead_ctrl runahead_ctrl_checker #(.PC_W(PC_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .runahead      (runahead),
  .ckptReq       (ckptReq),
  .demandReq     (demandReq),
  .prefetchReq   (prefetchReq),
  .storeCommit   (storeCommit),
  .restoreReq    (restoreReq),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc)
);

// File: tb/runahead_ctrl_bench.sv
module runahead_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int LINE_W = 32;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missValid = 1'b0, missIsLoad = 1'b0;
  logic [PC_W-1:0] missPc = '0;
  logic [LINE_W-1:0] missLineAddr = '0;
  logic [REG_W-1:0] missDestReg = '0;
  logic fillBusy = 1'b0, fillDone = 1'b0;
  logic [LINE_W-1:0] fillLineAddr = '0;
  logic storeValid = 1'b0;

  logic runahead, ckptReq, demandReq, invalidateReq, prefetchReq;
  logic storeCommit, restoreReq, redirectValid;
  logic [LINE_W-1:0] demandLineAddr, prefetchLineAddr;
  logic [REG_W-1:0] invalidateReg;
  logic [PC_W-1:0] redirectPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  runahead_ctrl u_runahead_ctrl (
    .clk(clk), .rst_n(rst_n),
    .missValid(missValid), .missIsLoad(missIsLoad), .missPc(missPc),
    .missLineAddr(missLineAddr), .missDestReg(missDestReg),
    .fillBusy(fillBusy), .fillDone(fillDone), .fillLineAddr(fillLineAddr),
    .storeValid(storeValid),
    .runahead(runahead), .ckptReq(ckptReq), .demandReq(demandReq),
    .demandLineAddr(demandLineAddr), .invalidateReq(invalidateReq),
    .invalidateReg(invalidateReg), .prefetchReq(prefetchReq),
    .prefetchLineAddr(prefetchLineAddr), .storeCommit(storeCommit),
    .restoreReq(restoreReq), .redirectValid(redirectValid),
    .redirectPc(redirectPc)
  );

  typedef struct {
    logic mode, ckpt, dem, inv, pf, commit, rst;
    logic [31:0] dAddr, pAddr, rpc;
    logic [4:0] iReg;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t ex(string tag, logic mode, ckpt, dem, logic [31:0] dAddr,
                              logic inv, logic [4:0] iReg, logic pf, logic [31:0] pAddr,
                              logic commit, rst, logic [31:0] rpc);
    exp_t e;
    e.tag = tag; e.mode = mode; e.ckpt = ckpt; e.dem = dem; e.dAddr = dAddr;
    e.inv = inv; e.iReg = iReg; e.pf = pf; e.pAddr = pAddr;
    e.commit = commit; e.rst = rst; e.rpc = rpc;
    return e;
  endfunction

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, nm, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the view expected after the edge
  task automatic step(logic m, ld, logic [31:0] pc, ln, logic [4:0] dr,
                      logic bz, fd, logic [31:0] fa, logic st, exp_t e);
    @(negedge clk);
    missValid = m; missIsLoad = ld; missPc = pc; missLineAddr = ln;
    missDestReg = dr; fillBusy = bz; fillDone = fd; fillLineAddr = fa;
    storeValid = st;
    q.push_back(e);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, "/R2"}, "runahead", {31'd0, runahead}, {31'd0, e.mode});
        chk({e.tag, "/R2"}, "ckptReq", {31'd0, ckptReq}, {31'd0, e.ckpt});
        chk({e.tag, "/R4"}, "demandReq", {31'd0, demandReq}, {31'd0, e.dem});
        if (e.dem) chk({e.tag, "/R4"}, "demandLineAddr", demandLineAddr, e.dAddr);
        chk({e.tag, "/R5"}, "invalidateReq", {31'd0, invalidateReq}, {31'd0, e.inv});
        if (e.inv) chk({e.tag, "/R5"}, "invalidateReg", {27'd0, invalidateReg}, {27'd0, e.iReg});
        chk({e.tag, "/R7"}, "prefetchReq", {31'd0, prefetchReq}, {31'd0, e.pf});
        if (e.pf) chk({e.tag, "/R7"}, "prefetchLineAddr", prefetchLineAddr, e.pAddr);
        chk({e.tag, "/R6"}, "storeCommit", {31'd0, storeCommit}, {31'd0, e.commit});
        chk({e.tag, "/R8"}, "restoreReq", {31'd0, restoreReq}, {31'd0, e.rst});
        chk({e.tag, "/R8"}, "redirectValid", {31'd0, redirectValid}, {31'd0, e.rst});
        if (e.mode) chk({e.tag, "/R3"}, "redirectPc", redirectPc, e.rpc);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, stores commit freely
    step(0,0,0,0,0, 0,0,0, 1, ex("R1",0,0,0,0,0,0,0,0,1,0,0));
    step(0,0,0,0,0, 0,0,0, 0, ex("R1",0,0,0,0,0,0,0,0,0,0,0));
    // R2/R4/R6: instruction-side miss, no fill outstanding, store blocked
    step(1,0,32'h100,32'h4000,0, 0,0,0, 1, ex("R2",1,1,1,32'h4000,0,0,0,0,0,0,32'h100));
    step(0,0,0,0,0, 0,0,0, 1, ex("R6",1,0,0,0,0,0,0,0,0,0,32'h100));
    // R7: second miss becomes a prefetch, PC kept
    step(1,1,32'h200,32'h5000,3, 0,0,0, 0, ex("R7",1,0,0,0,0,0,1,32'h5000,0,0,32'h100));
    // R9: fill for another line ignored
    step(0,0,0,0,0, 0,1,32'h5000, 0, ex("R9",1,0,0,0,0,0,0,0,0,0,32'h100));
    // R8: matching fill -> restore/redirect cycle, stores still blocked
    step(0,0,0,0,0, 0,1,32'h4000, 1, ex("R8",1,0,0,0,0,0,0,0,0,1,32'h100));
    // R10: miss in restore cycle dropped; back to normal
    step(1,1,32'h300,32'h7000,4, 0,0,0, 1, ex("R10",0,0,0,0,0,0,0,0,1,0,0));
    step(0,0,0,0,0, 0,0,0, 0, ex("R10",0,0,0,0,0,0,0,0,0,0,0));
    // R9: fill in normal mode ignored
    step(0,0,0,0,0, 0,1,32'h4000, 1, ex("R9",0,0,0,0,0,0,0,0,1,0,0));
    // R4/R5: load miss with fill already outstanding
    step(1,1,32'h340,32'h6000,7, 1,0,0, 0, ex("R5",1,1,0,0,1,7,0,0,0,0,32'h340));
    step(0,0,0,0,0, 0,1,32'h6000, 0, ex("R8",1,0,0,0,0,0,0,0,0,1,32'h340));
    step(0,0,0,0,0, 0,0,0, 1, ex("R8",0,0,0,0,0,0,0,0,1,0,0));
    // R5: non-load data miss flags nothing
    step(1,0,32'h480,32'h8000,9, 0,0,0, 0, ex("R5",1,1,1,32'h8000,0,0,0,0,0,0,32'h480));
    step(0,0,0,0,0, 0,1,32'h8000, 0, ex("R8",1,0,0,0,0,0,0,0,0,1,32'h480));
    step(0,0,0,0,0, 0,0,0, 0, ex("R1",0,0,0,0,0,0,0,0,0,0,0));
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule